// File: doc/BRIEF.md
# ARINC 429 Self-Test Word Transmitter

This block holds one 32-bit test word and sends it out serially as ARINC 429 return-to-zero symbols. A host command interface loads the word with a one-cycle strobe. The load command that is used also picks the bit rate. Transmission starts on its own at the clock edge that takes the load.

The symbol stream drives a two-wire digital pair. That pair is meant for an external line driver. The same stream also drives an internal loopback pair that all receiver channels share. Both pairs always carry the same stream, whether or not any receiver listens to the loopback. A busy flag tells the host when a new word may be loaded. Each word is followed by a fixed idle gap before busy drops.

Both bit rates come from the system clock through parameters. The defaults give 100 kbit/s and 12.5 kbit/s from a 50 MHz clock.

Top module: `a429_selftest_tx`

## Requirements
- R1: While reset is active, and after reset is released with no load, `tx_o` and `lb_o` are 2'b00 (NULL) and `busy_o` is 0.
- R2: A load is accepted when `load_i` is 1 and `busy_o` is 0 at a rising clock edge. From the next cycle on, `busy_o` is 1 and bit 0 of the word is on the pair.
- R3: Bits go out LSB first. Bit slot k (k = 0..31) carries `word_i[k]` as it was at the accepted load.
- R4: The line encoding uses `tx_o[1]` as the ONE wire and `tx_o[0]` as the ZERO wire. ONE is 2'b10, ZERO is 2'b01 and NULL is 2'b00. The value 2'b11 never appears.
- R5: Each bit lasts 2H cycles. The data symbol is held for the first H cycles and NULL for the last H cycles.
- R6: The value of H depends on `rate_hi_i` at the accepted load. It is CLK_HZ/(2*HI_BPS) when `rate_hi_i` is 1 and CLK_HZ/(2*LO_BPS) when it is 0.
- R7: After bit 31 the pair stays NULL for 8H cycles (four bit times) with `busy_o` still 1. `busy_o` then falls, so it is high for exactly 72H cycles per word.
- R8: A load that arrives while `busy_o` is 1 is ignored. It changes neither the word being sent, nor its rate, nor its timing.
- R9: `lb_o` equals `tx_o` in every cycle, idle cycles included.
- R10: An asynchronous reset in the middle of a word forces NULL and `busy_o`=0 at once. The next load after that starts a fresh word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Word-load strobe from the host command decoder |
| rate_hi_i | input | 1 | 1: the high-speed load command was used; 0: the low-speed one |
| word_i | input | 32 | Test word, with bit 0 sent first |
| tx_o | output | 2 | Driver control pair {one, zero} |
| lb_o | output | 2 | Loopback pair to the receivers, same encoding as `tx_o` |
| busy_o | output | 1 | Word or inter-word gap in progress |

## Verification
A wrong half-period counter or a wrong latched rate changes where the first symbol edge falls. That shows up as a mismatch within H+1 cycles of the load. A shift register or half-bit counter that is off by one moves data into the wrong slot, and a per-cycle comparison catches this within one bit time. A gap counter or busy flag that is wrong only shows at the end of a word, up to 72H cycles after the load. For that reason back-to-back words and a load issued while busy are both run.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned GAP_BITS = 4;
  localparam int unsigned HALVES   = 2 * (WORD_W + GAP_BITS);

  typedef enum logic [1:0] {
    LINE_NULL = 2'b00,
    LINE_ZERO = 2'b01,
    LINE_ONE  = 2'b10
  } line_e;
endpackage

// File: rtl/a429_half_timer.sv
module a429_half_timer #(
  parameter int unsigned HI_HALF = 250,
  parameter int unsigned LO_HALF = 2000,
  localparam int unsigned MAX_HALF = (HI_HALF > LO_HALF) ? HI_HALF : LO_HALF,
  localparam int unsigned CNT_W = $clog2(MAX_HALF + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rate_hi_i,
  input  logic run_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= CNT_W'(HI_HALF);
    end else if (start_i) begin
      cnt_q <= '0;
      len_q <= rate_hi_i ? CNT_W'(HI_HALF) : CNT_W'(LO_HALF);
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && (cnt_q == len_q - 1'b1);

  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_q));
  p_rate_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> $stable(len_q));
endmodule

// File: rtl/a429_shifter.sv
module a429_shifter #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] word_i,
  output logic             bit_o
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[WIDTH-1:1]};
  end

  assign bit_o = sh_q[0];

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(sh_q));
endmodule

// File: rtl/a429_seq.sv
module a429_seq
  import a429_tx_pkg::*;
#(
  localparam int unsigned HC_W = $clog2(HALVES)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic busy_o,
  output logic data_half_o,
  output logic shift_o
);
  logic [HC_W-1:0] hcnt_q;
  logic            busy_q;
  logic            in_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hcnt_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      hcnt_q <= '0;
    end else if (busy_q && tick_i) begin
      if (hcnt_q == HC_W'(HALVES - 1)) begin
        busy_q <= 1'b0;
        hcnt_q <= '0;
      end else begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  // even half-count = data half, odd = return-to-zero half
  assign in_data     = hcnt_q < HC_W'(2 * WORD_W);
  assign data_half_o = busy_q && in_data && !hcnt_q[0];
  assign shift_o     = busy_q && tick_i && in_data && hcnt_q[0];
  assign busy_o      = busy_q;

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_q && hcnt_q == '0));
  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> $stable(hcnt_q));
  p_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && hcnt_q == HC_W'(HALVES - 1)) |=> !busy_q);
endmodule

// File: rtl/a429_selftest_tx.sv
module a429_selftest_tx
  import a429_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned HI_BPS = 100_000,
  parameter int unsigned LO_BPS = 12_500,
  localparam int unsigned HI_HALF = CLK_HZ / (2 * HI_BPS),
  localparam int unsigned LO_HALF = CLK_HZ / (2 * LO_BPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rate_hi_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        tx_o,
  output logic [1:0]        lb_o,
  output logic              busy_o
);
  logic  start, tick, busy, data_half, shift, cur_bit;
  line_e line;

  assign start = load_i && !busy;

  a429_half_timer #(.HI_HALF(HI_HALF), .LO_HALF(LO_HALF)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .rate_hi_i, .run_i(busy), .tick_o(tick)
  );

  a429_shifter #(.WIDTH(WORD_W)) u_shift (
    .clk_i, .rst_ni, .load_i(start), .shift_i(shift), .word_i, .bit_o(cur_bit)
  );

  a429_seq u_seq (
    .clk_i, .rst_ni, .start_i(start), .tick_i(tick),
    .busy_o(busy), .data_half_o(data_half), .shift_o(shift)
  );

  always_comb begin
    if (!data_half)   line = LINE_NULL;
    else if (cur_bit) line = LINE_ONE;
    else              line = LINE_ZERO;
  end

  assign tx_o   = line;
  assign lb_o   = line;
  assign busy_o = busy;

  p_no_illegal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_o != 2'b11);
  p_idle_null_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (tx_o == 2'b00));
  p_rz_after_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_o != 2'b00 && tick) |=> (tx_o == 2'b00));
endmodule

// File: tb/sim_a429_selftest_tx.sv
module sim_a429_selftest_tx;
  localparam int unsigned CLK_HZ = 2_000_000;
  localparam int unsigned HI_BPS = 100_000;
  localparam int unsigned LO_BPS = 12_500;
  localparam int unsigned H_HI = CLK_HZ / (2 * HI_BPS);
  localparam int unsigned H_LO = CLK_HZ / (2 * LO_BPS);

  typedef struct {
    logic [1:0] tx;
    logic       busy;
    string      rq;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic        rate_hi_i = 1'b0;
  logic [31:0] word_i = '0;
  logic [1:0]  tx_o, lb_o;
  logic        busy_o;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   mon_en = 1'b0;
  int   cyc = 0;

  always #10 clk_i = ~clk_i;

  a429_selftest_tx #(.CLK_HZ(CLK_HZ), .HI_BPS(HI_BPS), .LO_BPS(LO_BPS)) u0 (
    .clk_i, .rst_ni, .load_i, .rate_hi_i, .word_i, .tx_o, .lb_o, .busy_o
  );

  // driver: one leading idle cycle, then 72H cycles per word
  task automatic send(input logic [31:0] w, input logic hi, input string tag);
    int h;
    h = hi ? H_HI : H_LO;
    @(posedge clk_i); #2;
    load_i = 1'b1; word_i = w; rate_hi_i = hi;
    q.push_back('{2'b00, 1'b0, "R2"});
    for (int b = 0; b < 32; b++) begin
      for (int k = 0; k < h; k++)
        q.push_back('{w[b] ? 2'b10 : 2'b01, 1'b1, {tag, " R3/R4/R5/R6 data"}});
      for (int k = 0; k < h; k++)
        q.push_back('{2'b00, 1'b1, {tag, " R5 rz"}});
    end
    for (int k = 0; k < 8 * h; k++)
      q.push_back('{2'b00, 1'b1, "R7 gap"});
    @(posedge clk_i); #2;
    load_i = 1'b0;
  endtask

  task automatic stray_load(input logic [31:0] w, input logic hi);
    @(posedge clk_i); #2;
    load_i = 1'b1; word_i = w; rate_hi_i = hi;
    @(posedge clk_i); #2;
    load_i = 1'b0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (3) @(posedge clk_i);
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (tx_o !== 2'b00 || lb_o !== 2'b00 || busy_o !== 1'b0) begin
      errors++;
      $display("FAIL %s: tx=%b lb=%b busy=%b expected tx=00 lb=00 busy=0",
               tag, tx_o, lb_o, busy_o);
    end
  endtask

  // monitor: compares one expected item per cycle
  always @(negedge clk_i) begin
    exp_t e;
    if (mon_en) begin
      if (q.size() != 0) e = q.pop_front();
      else e = '{2'b00, 1'b0, "R1 idle"};
      checks++;
      if (tx_o !== e.tx || busy_o !== e.busy) begin
        errors++;
        $display("FAIL %s: tx=%b busy=%b expected tx=%b busy=%b",
                 e.rq, tx_o, busy_o, e.tx, e.busy);
      end
      checks++;
      if (lb_o !== tx_o) begin
        errors++;
        $display("FAIL R9: lb=%b expected %b", lb_o, tx_o);
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190_000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #25;
    check_idle("R1 during reset");
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 after reset");
    mon_en = 1'b1;

    send(32'hA5A5_0F0F, 1'b1, "hi");
    drain();
    send(32'h8000_0001, 1'b0, "lo");
    repeat (300) @(posedge clk_i);
    stray_load(32'h1234_5678, 1'b1);  // R8: must not disturb low-rate word
    drain();
    send(32'hFFFF_FFFF, 1'b1, "ones");
    wait (q.size() == 0);
    send(32'h0000_0000, 1'b1, "zeros");  // back-to-back, R2 after R7
    repeat (100) @(posedge clk_i);
    stray_load(32'hFFFF_FFFF, 1'b0);  // R8 at high rate
    drain();

    // R10: abort mid-word
    send(32'h5555_AAAA, 1'b1, "abort");
    repeat (150) @(posedge clk_i);
    #2;
    rst_ni = 1'b0;
    q.delete();
    #1;
    check_idle("R10 async abort");
    @(posedge clk_i); #2;
    rst_ni = 1'b1;
    send(32'h0F0F_3C3C, 1'b1, "R10 restart");
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule